// File: doc/BRIEF.md
# Programmable Compare Timer

This block is an up-counting timer with one compare channel, programmed over a plain register port with address, write enable, write data and a combinational read-data return. A power-of-two prescaler divides the core clock into count ticks. On each tick the counter advances by one. When it reaches the programmed modulus it returns to zero and raises an overflow flag. Loading the modulus with all ones turns the counter into a free-running time base.

The single channel can be placed in software-compare mode. In that mode, a tick that moves the counter onto the channel value raises the channel flag. The flag drives the interrupt output whenever the channel interrupt enable is set. Both flags are cleared by writing 1 to them. The channel flag can be cleared either in its own control register or through a status register that mirrors it. A read-only parameter register reports the counter width, so that driver code can adapt its programming to the build.

Top module: `cmp_timer`

## Requirements
- R1: Offset 0x04 is read-only. Bits 23:16 read the counter width `CNT_W` (0x20 for the default build), all other bits read 0, and writes to this offset change nothing.
- R2: After reset every readable register reads 0, except offset 0x04, and `irq` is low.
- R3: Offset 0x10 bit 3 enables counting and bits 2:0 hold a prescale code `p`. While enabled, the counter (offset 0x14) advances by one every 2^p clocks; while disabled it holds. The modulus is at offset 0x18.
- R4: A tick taken while the counter equals the modulus loads 0 instead of advancing, and sets offset 0x10 bit 7 (overflow flag).
- R5: Writing 1 to offset 0x10 bit 7 clears the overflow flag and writing 0 leaves it. A wrap in the same cycle as the clearing write leaves it set.
- R6: Any write to offset 0x14 sets the counter to 0 whatever the data, restarts the prescale phase, and suppresses the tick of that cycle.
- R7: Offset 0x20 holds the channel flag (bit 7), the interrupt enable (bit 6) and a mode field (bits 5:2); offset 0x24 holds the channel value. Only mode 0x4 compares: a tick that moves the counter onto the channel value sets the flag. Any other mode, 0 included, sets nothing.
- R8: Offset 0x1C bit 0 reads the channel flag. Writing 1 to it, or to offset 0x20 bit 7, clears the flag unless a match occurs in the same cycle.
- R9: `irq` is high exactly while the channel flag and the interrupt enable are both set.
- R10: Reads of any offset other than 0x04, 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench targets the following cases:
- Same-cycle collisions: a clearing write against a new wrap or match, and a counter write against a due tick. A design with the wrong priority loses an event or counts once too often.
- Prescale codes changed while the counter runs, and the divide-by-128 extreme. These expose an off-by-one prescale phase.
- A counter that sits above a lowered modulus, and a channel value equal to the modulus or to zero. A wrong compare source misses these matches or fires twice.
- Non-compare modes, writes to the parameter offset and accesses to unmapped offsets. Each of these must leave every register unchanged.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PS_W   = 3;
  localparam int PCNT_W = (1 << PS_W) - 1;

  localparam logic [ADDR_W-1:0] OFF_PARAM = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MOD   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CHCTL = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CHVAL = 8'h24;

  localparam logic [3:0] MODE_SWCMP = 4'h4;

  // low bits of the prescale phase that must all be one for a tick
  function automatic logic [PCNT_W-1:0] ps_mask(input logic [PS_W-1:0] code);
    return (PCNT_W'(1) << code) - PCNT_W'(1);
  endfunction

  function automatic logic ps_hit(input logic [PCNT_W-1:0] phase,
                                  input logic [PS_W-1:0]   code);
    return (phase & ps_mask(code)) == ps_mask(code);
  endfunction
endpackage

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler
  import cmp_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  logic [PCNT_W-1:0] phase_q;

  assign tick = en && !clr && ps_hit(phase_q, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (!en || clr) phase_q <= '0;
    else                 phase_q <= phase_q + PCNT_W'(1);
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             wrap_evt
);
  assign wrap_evt = tick && !clr && (count == modulus);

  always_comb begin
    if (clr)           count_nxt = '0;
    else if (wrap_evt) count_nxt = '0;
    else if (tick)     count_nxt = count + CNT_W'(1);
    else               count_nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [3:0]       mode,
  input  logic             clr_req,
  output logic             flag,
  output logic             match_evt
);
  assign match_evt = tick && (mode == MODE_SWCMP) && (count_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= match_evt || (flag && !clr_req);
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  // control state
  logic             cnt_en;
  logic [PS_W-1:0]  ps_code;
  logic             ovf_flag;
  logic [CNT_W-1:0] mod_q;
  logic             ch_ie;
  logic [3:0]       ch_mode;
  logic [CNT_W-1:0] ch_val;

  // named internal events
  logic             tick;
  logic             wrap_evt;
  logic             match_evt;
  logic             chf_flag;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;

  logic wr_ctl, wr_cnt, wr_mod, wr_stat, wr_chctl, wr_chval;
  assign wr_ctl   = we && (addr == OFF_CTL);
  assign wr_cnt   = we && (addr == OFF_CNT);
  assign wr_mod   = we && (addr == OFF_MOD);
  assign wr_stat  = we && (addr == OFF_STAT);
  assign wr_chctl = we && (addr == OFF_CHCTL);
  assign wr_chval = we && (addr == OFF_CHVAL);

  logic chf_clr;
  assign chf_clr = (wr_chctl && wdata[7]) || (wr_stat && wdata[0]);

  cmp_timer_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .clr  (wr_cnt),
    .code (ps_code),
    .tick (tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (wr_cnt),
    .modulus  (mod_q),
    .count    (count),
    .count_nxt(count_nxt),
    .wrap_evt (wrap_evt)
  );

  cmp_timer_channel #(.CNT_W(CNT_W)) u_ch0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count_nxt(count_nxt),
    .cmp_val  (ch_val),
    .mode     (ch_mode),
    .clr_req  (chf_clr),
    .flag     (chf_flag),
    .match_evt(match_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en   <= 1'b0;
      ps_code  <= '0;
      ovf_flag <= 1'b0;
      mod_q    <= '0;
      ch_ie    <= 1'b0;
      ch_mode  <= '0;
      ch_val   <= '0;
    end else begin
      ovf_flag <= wrap_evt || (ovf_flag && !(wr_ctl && wdata[7]));
      if (wr_ctl) begin
        cnt_en  <= wdata[3];
        ps_code <= wdata[PS_W-1:0];
      end
      if (wr_mod) mod_q <= wdata[CNT_W-1:0];
      if (wr_chctl) begin
        ch_ie   <= wdata[6];
        ch_mode <= wdata[5:2];
      end
      if (wr_chval) ch_val <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_PARAM: rdata[23:16] = 8'(CNT_W);
      OFF_CTL:   rdata = {24'h0, ovf_flag, 3'b000, cnt_en, ps_code};
      OFF_CNT:   rdata = DATA_W'(count);
      OFF_MOD:   rdata = DATA_W'(mod_q);
      OFF_STAT:  rdata = {31'h0, chf_flag};
      OFF_CHCTL: rdata = {24'h0, chf_flag, ch_ie, ch_mode, 2'b00};
      OFF_CHVAL: rdata = DATA_W'(ch_val);
      default:   rdata = '0;
    endcase
  end

  assign irq = chf_flag && ch_ie;
endmodule

// File: rtl/cmp_timer_sva.sv
module cmp_timer_sva
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              tick,
  input logic              wrap_evt,
  input logic              match_evt,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              chf_flag,
  input logic              ch_ie,
  input logic              cnt_en
);
  p_param_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_PARAM) |-> (rdata[23:16] == 8'(CNT_W)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !(we && addr == OFF_CNT)) |=> $stable(count));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_evt) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0 && ovf_flag));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_CNT) |=> (count == '0));

  p_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> chf_flag);

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_STAT) |-> (rdata[0] == chf_flag));

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chf_flag || !ch_ie) |-> !irq);
endmodule

bind cmp_timer cmp_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .we       (we),
  .addr     (addr),
  .rdata    (rdata),
  .irq      (irq),
  .tick     (tick),
  .wrap_evt (wrap_evt),
  .match_evt(match_evt),
  .count    (count),
  .ovf_flag (ovf_flag),
  .chf_flag (chf_flag),
  .ch_ie    (ch_ie),
  .cnt_en   (cnt_en)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CNT_W = 32;
  localparam longint unsigned CMASK = (CNT_W >= 64) ? '1 : ((64'd1 << CNT_W) - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // reference model state
  bit              m_en, m_ovf, m_ie, m_chf;
  int unsigned     m_ps, m_p, m_mode;
  longint unsigned m_cnt, m_mod, m_cv;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h04: return 32'(CNT_W) << 16;
      8'h10: return (32'(m_ovf) << 7) | (32'(m_en) << 3) | 32'(m_ps);
      8'h14: return 32'(m_cnt);
      8'h18: return 32'(m_mod);
      8'h1C: return 32'(m_chf);
      8'h20: return (32'(m_chf) << 7) | (32'(m_ie) << 6) | (32'(m_mode) << 2);
      8'h24: return 32'(m_cv);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h04: return "R1";
      8'h10: return "R4 R5";
      8'h14: return "R3 R6";
      8'h18: return "R3";
      8'h1C: return "R8";
      8'h20, 8'h24: return "R7";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ovf = 0; m_ie = 0; m_chf = 0;
      m_ps = 0; m_p = 0; m_mode = 0; m_cnt = 0; m_mod = 0; m_cv = 0;
    end else begin
      bit cw, tk, wr, mt, n_ovf, n_chf;
      int unsigned dv, np;
      longint unsigned nc;
      cw = we && addr == 8'h14;
      dv = 1 << m_ps;
      tk = m_en && !cw && ((m_p % dv) == dv - 1);
      wr = tk && (m_cnt == m_mod);
      nc = cw ? 0 : (tk ? (wr ? 0 : ((m_cnt + 1) & CMASK)) : m_cnt);
      mt = tk && m_mode == 4 && nc == m_cv;
      np = (!m_en || cw) ? 0 : (m_p + 1) % 128;
      n_ovf = wr || (m_ovf && !(we && addr == 8'h10 && wdata[7]));
      n_chf = mt || (m_chf && !(we && ((addr == 8'h20 && wdata[7]) ||
                                        (addr == 8'h1C && wdata[0]))));
      if (we && addr == 8'h10) begin m_en = wdata[3]; m_ps = wdata[2:0]; end
      if (we && addr == 8'h18) m_mod = wdata & CMASK;
      if (we && addr == 8'h20) begin m_ie = wdata[6]; m_mode = wdata[5:2]; end
      if (we && addr == 8'h24) m_cv = wdata & CMASK;
      m_cnt = nc; m_p = np; m_ovf = n_ovf; m_chf = n_chf;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, check read data and irq against the model
  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input string extra = "");
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
    chk({extra, req_of(a)}, rdata, m_read(a));
    chk("R9 irq", 32'(irq), 32'(m_chf && m_ie));
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) step(0, a, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] unm [6] = '{8'h00, 8'h08, 8'h0C, 8'h28, 8'h40, 8'hFC};
    logic [7:0] mapped [7] = '{8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: reset values, directly against constants
    foreach (mapped[i]) begin
      @(negedge clk); addr = mapped[i]; #1;
      chk("R2 reset", rdata, (mapped[i] == 8'h04) ? 32'h0020_0000 : 32'h0);
    end
    chk("R2 irq", 32'(irq), 32'h0);

    // R1: parameter offset is read-only
    step(1, 8'h04, 32'hFFFF_FFFF);
    step(0, 8'h04, 32'h0);
    chk("R1 const", rdata, 32'h0020_0000);

    // R3/R4: modulus 5, divide by 1, then divide by 4
    step(1, 8'h18, 32'd5);
    step(1, 8'h10, 32'h08);
    idle(14, 8'h14);
    step(1, 8'h10, 32'h0A);
    idle(30, 8'h14);
    // R5: clear overflow, write 0 keeps it
    step(1, 8'h10, 32'h0A);
    step(1, 8'h10, 32'h8A);
    idle(3, 8'h10);
    // R6: counter write with nonzero data
    step(1, 8'h14, 32'hDEAD_BEEF, "R6 ");
    idle(6, 8'h14);
    // divide by 128 with a large modulus
    step(1, 8'h18, 32'hFFFF_FFFF);
    step(1, 8'h10, 32'h0F);
    idle(400, 8'h14);

    // R7/R9: compare at 3, divide by 1, modulus 6
    step(1, 8'h18, 32'd6);
    step(1, 8'h10, 32'h08);
    step(1, 8'h14, 32'h0);
    step(1, 8'h24, 32'd3);
    step(1, 8'h20, 32'h50);
    idle(10, 8'h20);
    // R8: clear through status, then through channel control
    step(1, 8'h1C, 32'h1);
    idle(5, 8'h1C);
    step(1, 8'h20, 32'hD0);
    idle(4, 8'h20);
    // R7: mode 0 and another mode never flag
    step(1, 8'h20, 32'h80);
    idle(20, 8'h20);
    step(1, 8'h20, 32'h48);
    idle(20, 8'h1C);

    // R10: unmapped offsets
    foreach (unm[i]) begin
      step(1, unm[i], 32'hFFFF_FFFF);
      step(0, unm[i], 32'h0);
    end

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [31:0] d;
      r = $urandom % 100;
      d = $urandom;
      if (r < 30)      step(0, mapped[$urandom % 7], 32'h0);
      else if (r < 45) step(1, 8'h10, {24'h0, d[7], 3'b0, ($urandom % 8) != 0, 1'b0, d[1:0]});
      else if (r < 55) step(1, 8'h18, $urandom % 24);
      else if (r < 63) step(1, 8'h24, $urandom % 24);
      else if (r < 73) step(1, 8'h20, {24'h0, d[7], d[6], (d[10:8] != 0) ? 4'h4 : d[5:2], 2'b0});
      else if (r < 80) step(1, 8'h1C, d);
      else if (r < 84) step(1, 8'h14, d);
      else if (r < 90) step(d[12], unm[$urandom % 6], d);
      else if (r < 93) step(1, 8'h04, d);
      else             step(0, 8'h14, 32'h0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule